// File: doc/BRIEF.md
# Branch Condition and Count Evaluator

This block resolves one conditional branch per cycle. From a 5-bit option field it builds the branch condition by combining up to two tests. The first is a count test: the count register is decremented and the result is checked for zero or non-zero. The second is a test of a single condition bit against an expected value. When both tests are active the branch condition is their AND. The block then picks the next instruction address. That is the branch target when the condition holds, and the sequential fall-through address when it does not.

The target comes from one of three sources: the relative target supplied by the decoder, the link register, or the count register. A target taken from the link or count register always has its two low bits forced to zero. The block also reports the write-back values for the count register (the decremented value) and for the link register (an immediate return address).

All results are registered and appear one cycle after the request. This lets the block sit between decode and the next-address mux of a fetch unit.

Top module: `bru_eval`

## Requirements
- R1: `vld_o` is `vld_i` delayed by exactly one clock. While reset is high, and in any cycle after one with `vld_i` low, `vld_o`, `taken_o`, `ctr_we_o` and `lr_we_o` are 0.
- R2: The option field is decoded bit by bit:
  - bit 4 = 1 skips the count test;
  - bit 3 = 1 requires the decremented count to be zero, and 0 requires it to be non-zero;
  - bit 2 = 1 skips the condition-bit test;
  - bit 1 is the value the condition bit must have;
  - bit 0 = 1 requests a link update.
- R3: When the count test is active, `ctr_we_o` is 1 and `ctr_o` is `ctr_i` minus one, modulo 2^W. The zero test uses this decremented value, so a count of 0 becomes all ones, which counts as non-zero.
- R4: When the target select is the count register (`sel_i` = 2), the count register is neither decremented nor tested, whatever bit 4 holds, and `ctr_we_o` is 0.
- R5: `taken_o` is the AND of the active tests. With both tests skipped, the branch is always taken.
- R6: `sel_i` chooses the target: 0 and 3 select `rel_i`, 1 selects `lr_i` with bits [1:0] cleared, and 2 selects `ctr_i` with bits [1:0] cleared. When taken, `next_o` is this target.
- R7: When the condition fails, `next_o` equals `seq_i`.
- R8: Option bit 0 sets `lr_we_o` and makes `lr_o` equal to `ret_i`, whether or not the branch is taken. A link-register target uses `lr_i`, the value held before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Request valid |
| opt_i | input | 5 | Option field (R2) |
| cbit_i | input | 1 | Condition bit under test |
| ctr_i | input | W | Current count register |
| sel_i | input | 2 | Target select (R6) |
| seq_i | input | W | Fall-through address |
| rel_i | input | W | Relative target address |
| lr_i | input | W | Current link register |
| ret_i | input | W | Return address for the link update |
| vld_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_o | output | W | Next instruction address |
| ctr_we_o | output | 1 | Count register write enable |
| ctr_o | output | W | New count register value |
| lr_we_o | output | 1 | Link register write enable |
| lr_o | output | W | New link register value |

## Verification
The block holds no state across requests besides its result register, so any fault appears on the very next cycle's outputs. A wrong decrement shows in `ctr_o`, and also flips `taken_o` for counts of 1 and 0, which sit on either side of the zero test. A mis-decoded option bit or a wrong target source shows as a wrong `taken_o`/`next_o` pair, or as an unaligned indirect target.

The sweep covers every option value, both condition-bit values, every target select and counts around zero. Every output is compared on each request, which exposes such faults at once.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [1:0] {
        TGT_REL  = 2'd0,
        TGT_LINK = 2'd1,
        TGT_CNT  = 2'd2,
        TGT_RSV  = 2'd3
    } tgt_sel_e;

    // Packed MSB first: bit4 .. bit0
    typedef struct packed {
        logic skip_ctr;
        logic take_on_zero;
        logic skip_bit;
        logic want_bit;
        logic link_upd;
    } bopt_t;

    function automatic logic bit_test_ok(bopt_t o, logic b);
        return o.skip_bit | (b == o.want_bit);
    endfunction

    function automatic logic ctr_active(bopt_t o, tgt_sel_e s);
        return !o.skip_ctr && (s != TGT_CNT);
    endfunction

endpackage

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
#(
    parameter int W = 32
) (
    input  bopt_t       opt,
    input  tgt_sel_e    sel,
    input  logic        cbit,
    input  logic [W-1:0] ctr,
    output logic        cond_ok,
    output logic        dec_en,
    output logic [W-1:0] ctr_nxt
);
    logic ctr_zero;
    logic ctr_ok;

    always_comb begin
        dec_en   = ctr_active(opt, sel);
        ctr_nxt  = ctr - W'(1);
        ctr_zero = (ctr_nxt == '0);
        ctr_ok   = !dec_en || (ctr_zero == opt.take_on_zero);
        cond_ok  = ctr_ok && bit_test_ok(opt, cbit);
    end
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int W = 32
) (
    input  tgt_sel_e     sel,
    input  logic [W-1:0] rel,
    input  logic [W-1:0] lr,
    input  logic [W-1:0] ctr,
    output logic [W-1:0] tgt
);
    localparam logic [W-1:0] ALIGN_MASK = ~W'(3);

    always_comb begin
        unique case (sel)
            TGT_LINK: tgt = lr & ALIGN_MASK;
            TGT_CNT:  tgt = ctr & ALIGN_MASK;
            default:  tgt = rel;
        endcase
    end
endmodule

// File: rtl/bru_eval.sv
module bru_eval
    import bru_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [4:0]   opt_i,
    input  logic         cbit_i,
    input  logic [W-1:0] ctr_i,
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] seq_i,
    input  logic [W-1:0] rel_i,
    input  logic [W-1:0] lr_i,
    input  logic [W-1:0] ret_i,
    output logic         vld_o,
    output logic         taken_o,
    output logic [W-1:0] next_o,
    output logic         ctr_we_o,
    output logic [W-1:0] ctr_o,
    output logic         lr_we_o,
    output logic [W-1:0] lr_o
);
    bopt_t        opt;
    tgt_sel_e     sel;
    logic         cond_ok;
    logic         dec_en;
    logic [W-1:0] ctr_nxt;
    logic [W-1:0] tgt;

    assign opt = bopt_t'(opt_i);
    assign sel = tgt_sel_e'(sel_i);

    bru_cond #(.W(W)) u_cond (
        .opt    (opt),
        .sel    (sel),
        .cbit   (cbit_i),
        .ctr    (ctr_i),
        .cond_ok(cond_ok),
        .dec_en (dec_en),
        .ctr_nxt(ctr_nxt)
    );

    bru_target #(.W(W)) u_tgt (
        .sel(sel),
        .rel(rel_i),
        .lr (lr_i),
        .ctr(ctr_i),
        .tgt(tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o    <= 1'b0;
            taken_o  <= 1'b0;
            next_o   <= '0;
            ctr_we_o <= 1'b0;
            ctr_o    <= '0;
            lr_we_o  <= 1'b0;
            lr_o     <= '0;
        end else begin
            vld_o    <= vld_i;
            taken_o  <= vld_i && cond_ok;
            ctr_we_o <= vld_i && dec_en;
            lr_we_o  <= vld_i && opt.link_upd;
            if (vld_i) begin
                next_o <= cond_ok ? tgt : seq_i;
                ctr_o  <= ctr_nxt;
                lr_o   <= ret_i;
            end
        end
    end
endmodule

// File: rtl/bru_eval_chk.sv
module bru_eval_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         vld_i,
    input logic [4:0]   opt_i,
    input logic         cbit_i,
    input logic [W-1:0] ctr_i,
    input logic [1:0]   sel_i,
    input logic [W-1:0] seq_i,
    input logic [W-1:0] rel_i,
    input logic [W-1:0] lr_i,
    input logic [W-1:0] ret_i,
    input logic         vld_o,
    input logic         taken_o,
    input logic [W-1:0] next_o,
    input logic         ctr_we_o,
    input logic [W-1:0] ctr_o,
    input logic         lr_we_o,
    input logic [W-1:0] lr_o
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> (!vld_o && !taken_o && !ctr_we_o && !lr_we_o));

    // R3
    ctr_dec_chk: assert property (@(posedge clk) disable iff (rst)
        ctr_we_o |-> (ctr_o == $past(ctr_i) - W'(1)));

    // R4
    cnt_tgt_nodec_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_o && $past(sel_i) == 2'd2) |-> !ctr_we_o);

    // R5
    always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_o && $past(opt_i[4]) && $past(opt_i[2])) |-> taken_o);

    // R6
    link_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_o && taken_o && $past(sel_i) == 2'd1) |-> (next_o == ($past(lr_i) & ~W'(3))));

    // R7
    fallthru_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !taken_o) |-> (next_o == $past(seq_i)));

    // R8
    link_upd_chk: assert property (@(posedge clk) disable iff (rst)
        lr_we_o |-> (lr_o == $past(ret_i)));
endmodule

bind bru_eval bru_eval_chk #(.W(W)) u_chk (.*);

// File: tb/sim_bru_eval.sv
module sim_bru_eval;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         vld_i = 1'b0;
    logic [4:0]   opt_i = '0;
    logic         cbit_i = 1'b0;
    logic [W-1:0] ctr_i = '0;
    logic [1:0]   sel_i = '0;
    logic [W-1:0] seq_i = '0;
    logic [W-1:0] rel_i = '0;
    logic [W-1:0] lr_i = '0;
    logic [W-1:0] ret_i = '0;
    logic         vld_o, taken_o, ctr_we_o, lr_we_o;
    logic [W-1:0] next_o, ctr_o, lr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bru_eval #(.W(W)) u0 (.*);

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [4:0] o, input logic cb, input logic [W-1:0] c,
                           input logic [1:0] s, input int idx);
        logic dec, zero, cok, bok, tk;
        logic [W-1:0] cn, tg, nx;
        @(negedge clk);
        vld_i  = 1'b1;
        opt_i  = o;
        cbit_i = cb;
        ctr_i  = c;
        sel_i  = s;
        seq_i  = 32'h4000_0000 + W'(idx * 4);
        rel_i  = 32'h5000_0001 + W'(idx * 8);
        lr_i   = 32'h6000_0003 + W'(idx * 16);
        ret_i  = 32'h7000_0000 + W'(idx);
        // expected values from the requirements (R2..R8)
        dec  = !o[4] && (s != 2'd2);
        cn   = c - 1;
        zero = (cn == 0);
        cok  = !dec || (zero == o[3]);
        bok  = o[2] || (cb == o[1]);
        tk   = cok && bok;
        case (s)
            2'd1:    tg = lr_i & 32'hFFFF_FFFC;
            2'd2:    tg = c & 32'hFFFF_FFFC;
            default: tg = rel_i;
        endcase
        nx = tk ? tg : seq_i;
        @(posedge clk);
        #1;
        chk("R1 vld", W'(vld_o), W'(1));
        chk("R5 taken", W'(taken_o), W'(tk));
        if (tk) chk("R6 target", next_o, nx);
        else    chk("R7 fallthru", next_o, nx);
        chk("R3/R4 ctr_we", W'(ctr_we_o), W'(dec));
        if (dec) chk("R3 ctr value", ctr_o, cn);
        chk("R8 lr_we", W'(lr_we_o), W'(o[0]));
        if (o[0]) chk("R8 lr value", lr_o, ret_i);
    endtask

    initial begin
        logic [W-1:0] cvals [5];
        int idx;
        cvals[0] = 32'h0000_0000;
        cvals[1] = 32'h0000_0001;
        cvals[2] = 32'h0000_0002;
        cvals[3] = 32'hFFFF_FFFF;
        cvals[4] = 32'h0000_0013;
        idx = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 reset vld", W'(vld_o), W'(0));
        chk("R1 reset taken", W'(taken_o), W'(0));
        chk("R1 reset ctr_we", W'(ctr_we_o), W'(0));
        chk("R1 reset lr_we", W'(lr_we_o), W'(0));
        @(negedge clk);
        rst = 1'b0;
        // R2 full sweep of option field, bit, count and select
        for (int o = 0; o < 32; o++)
            for (int cb = 0; cb < 2; cb++)
                for (int ci = 0; ci < 5; ci++)
                    for (int s = 0; s < 4; s++) begin
                        run_one(5'(o), 1'(cb), cvals[ci], 2'(s), idx);
                        idx++;
                    end
        // R1 idle after a valid request
        @(negedge clk);
        vld_i = 1'b0;
        opt_i = 5'b00001;
        @(posedge clk);
        #1;
        chk("R1 idle vld", W'(vld_o), W'(0));
        chk("R1 idle taken", W'(taken_o), W'(0));
        chk("R1 idle ctr_we", W'(ctr_we_o), W'(0));
        chk("R1 idle lr_we", W'(lr_we_o), W'(0));
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 100000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule